// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Full Condition Byte

This block is the arithmetic and logic stage of an 8-bit CPU datapath. Each operation takes an accumulator byte, a second operand byte, the current condition byte and a 4-bit operation code. It returns the new result byte, a write-enable that says whether the result should replace the accumulator, and a complete new condition byte. The condition byte covers every bit position, including the two otherwise unused positions 3 and 5. Those two bits are normally copies of the result bits, except during a compare.

The arithmetic core is purely combinational. A thin top registers its outputs when `opStrobe` is high, so that the surrounding pipeline, or a bench, sees the result on a clock boundary. When `opStrobe` is low, the registered outputs hold their values.

Condition byte layout (bit 7 down to bit 0): sign, zero, copy5, half-carry, copy3, parity/overflow, subtract, carry.

Top module: `byteAluFlags`

## Requirements
- R1: On reset (rstN low) every output is zero. On a rising clock edge with `opStrobe` high, the outputs take the values for the current inputs. With `opStrobe` low, the outputs hold.
- R2: Opcode 0 adds and opcode 1 adds with carry-in (condition bit 0). The sum is written back. Carry (bit 0) is bit 8 of the 9-bit sum. Half-carry (bit 4) is the carry out of the low nibble. Bit 2 is signed overflow. Bit 1 is cleared. Sign (bit 7), zero (bit 6), bit 5 and bit 3 come from the result.
- R3: Opcode 2 subtracts and opcode 3 subtracts with borrow-in (condition bit 0). The difference is written back. Bit 1 is set. Carry is the borrow out of bit 7. Half-carry is the borrow out of the low nibble. Bit 2 is signed overflow. Sign, zero, bit 5 and bit 3 come from the result.
- R4: Opcode 4 (compare) computes accumulator minus operand with the R3 rules, but returns the accumulator unchanged with write-enable low. Its bits 5 and 3 are copied from the operand. Its sign and zero come from the difference.
- R5: Opcodes 5, 6 and 7 are AND, OR and XOR. Half-carry is 1 for AND and 0 for OR and XOR. Bits 1 and 0 are cleared. Bit 2 is 1 when the result has an even number of one bits. Sign, zero, bit 5 and bit 3 come from the result.
- R6: Opcode 8 increments the accumulator. It keeps the incoming carry and clears bit 1. Half-carry is set when the low nibble of the result is 0. Bit 2 is set when the result is 0x80.
- R7: Opcode 9 decrements the accumulator. It keeps the incoming carry and sets bit 1. Half-carry is set when the low nibble of the original accumulator is 0. Bit 2 is set when the result is 0x7F.
- R8: Opcode 10 negates: it returns 0 minus the accumulator with the R3 condition rules.
- R9: Opcodes 11 to 15 return the accumulator and the incoming condition byte unchanged, with write-enable low.
- R10: Write-enable is high for opcodes 0–3 and 5–10, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opStrobe | input | 1 | Latch the outputs for the current inputs |
| opCode | input | 4 | Operation select |
| accIn | input | 8 | Accumulator byte |
| operandIn | input | 8 | Second operand byte |
| condIn | input | 8 | Incoming condition byte |
| resultOut | output | 8 | Registered result byte |
| condOut | output | 8 | Registered condition byte |
| writeEnOut | output | 1 | Registered result write-enable |

## Verification
Every result, condition byte and write-enable appears one clock edge after the edge that samples `opStrobe` high. The bench drives stimulus on the falling edge, lets a single rising edge latch it, and reads the outputs on the next falling edge. The hold check drops the strobe, changes every input, waits two edges, and confirms that the latched values did not move. The checker's properties likewise compare each output against the inputs from exactly one cycle earlier.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  // condition byte bit positions
  localparam int B_CARRY = 0;
  localparam int B_SUBTR = 1;
  localparam int B_PV    = 2;
  localparam int B_COPY3 = 3;
  localparam int B_HALF  = 4;
  localparam int B_COPY5 = 5;
  localparam int B_ZERO  = 6;
  localparam int B_SIGN  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_NEG = 4'd10
  } aluOp_e;

  typedef enum logic [1:0] { LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2 } logicSel_e;

  typedef struct packed {
    logic      doSub;      // subtract rather than add
    logic      useCarry;   // fold incoming carry into arithmetic
    logic      useOne;     // second term is constant one
    logic      negate;     // first term zero, second term accumulator
    logic      isLogic;    // bitwise path
    logicSel_e logicSel;
    logic      keepCarry;  // carry passes through
    logic      copyFromOp; // bits 5/3 from operand, no writeback
    logic      writeEn;
    logic      passThru;   // unused code
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.logicSel = LG_AND;
    unique case (opCode)
      OP_ADD: ctrl.writeEn = 1'b1;
      OP_ADC: begin ctrl.useCarry = 1'b1; ctrl.writeEn = 1'b1; end
      OP_SUB: begin ctrl.doSub = 1'b1; ctrl.writeEn = 1'b1; end
      OP_SBC: begin ctrl.doSub = 1'b1; ctrl.useCarry = 1'b1; ctrl.writeEn = 1'b1; end
      OP_CMP: begin ctrl.doSub = 1'b1; ctrl.copyFromOp = 1'b1; end
      OP_AND: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_AND; ctrl.writeEn = 1'b1; end
      OP_OR:  begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_OR;  ctrl.writeEn = 1'b1; end
      OP_XOR: begin ctrl.isLogic = 1'b1; ctrl.logicSel = LG_XOR; ctrl.writeEn = 1'b1; end
      OP_INC: begin ctrl.useOne = 1'b1; ctrl.keepCarry = 1'b1; ctrl.writeEn = 1'b1; end
      OP_DEC: begin
        ctrl.useOne = 1'b1; ctrl.keepCarry = 1'b1; ctrl.doSub = 1'b1; ctrl.writeEn = 1'b1;
      end
      OP_NEG: begin ctrl.negate = 1'b1; ctrl.doSub = 1'b1; ctrl.writeEn = 1'b1; end
      default: ctrl.passThru = 1'b1;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [DATA_W-1:0] condIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] cond,
  output logic              writeEn
);
  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] termX, termY, logicRes, mainRes, finalRes;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    nib;
  logic              carryIn, halfFlag, ovfFlag, carryFlag;

  assign termX   = ctrl.negate ? '0 : accIn;
  assign termY   = ctrl.negate ? accIn : (ctrl.useOne ? DATA_W'(1) : operandIn);
  assign carryIn = ctrl.useCarry & condIn[B_CARRY];

  always_comb begin
    if (ctrl.doSub) begin
      wide = {1'b0, termX} - {1'b0, termY} - {{DATA_W{1'b0}}, carryIn};
      nib  = {1'b0, termX[NIB_W-1:0]} - {1'b0, termY[NIB_W-1:0]} - {{NIB_W{1'b0}}, carryIn};
    end else begin
      wide = {1'b0, termX} + {1'b0, termY} + {{DATA_W{1'b0}}, carryIn};
      nib  = {1'b0, termX[NIB_W-1:0]} + {1'b0, termY[NIB_W-1:0]} + {{NIB_W{1'b0}}, carryIn};
    end
  end

  always_comb begin
    unique case (ctrl.logicSel)
      LG_OR:   logicRes = accIn | operandIn;
      LG_XOR:  logicRes = accIn ^ operandIn;
      default: logicRes = accIn & operandIn;
    endcase
  end

  // signed overflow: operands agree (add) or differ (sub), result sign flips
  assign ovfFlag = (ctrl.doSub ? (termX[TOP] ^ termY[TOP]) : ~(termX[TOP] ^ termY[TOP]))
                   & (wide[TOP] ^ termX[TOP]);

  assign mainRes   = ctrl.isLogic ? logicRes : wide[DATA_W-1:0];
  assign halfFlag  = ctrl.isLogic ? (ctrl.logicSel == LG_AND) : nib[NIB_W];
  assign carryFlag = ctrl.isLogic ? 1'b0 : (ctrl.keepCarry ? condIn[B_CARRY] : wide[DATA_W]);

  always_comb begin
    if (ctrl.passThru) begin
      finalRes = accIn;
      cond     = condIn;
    end else begin
      finalRes        = (ctrl.copyFromOp) ? accIn : mainRes;
      cond[B_SIGN]    = mainRes[TOP];
      cond[B_ZERO]    = (mainRes == '0);
      cond[B_COPY5]   = ctrl.copyFromOp ? operandIn[B_COPY5] : mainRes[B_COPY5];
      cond[B_COPY3]   = ctrl.copyFromOp ? operandIn[B_COPY3] : mainRes[B_COPY3];
      cond[B_HALF]    = halfFlag;
      cond[B_PV]      = ctrl.isLogic ? ~(^mainRes) : ovfFlag;
      cond[B_SUBTR]   = ctrl.doSub;
      cond[B_CARRY]   = carryFlag;
    end
  end

  assign result  = finalRes;
  assign writeEn = ctrl.writeEn;
endmodule

// File: rtl/byteAluFlags.sv
module byteAluFlags
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStrobe,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [DATA_W-1:0] condIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] condOut,
  output logic              writeEnOut
);
  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] nextRes, nextCond;
  logic              nextWe;

  aluControl u_ctrl (.opCode(opCode), .ctrl(ctrl));

  aluDatapath u_dp (
    .ctrl(ctrl), .accIn(accIn), .operandIn(operandIn), .condIn(condIn),
    .result(nextRes), .cond(nextCond), .writeEn(nextWe)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut  <= '0;
      condOut    <= '0;
      writeEnOut <= 1'b0;
    end else if (opStrobe) begin
      resultOut  <= nextRes;
      condOut    <= nextCond;
      writeEnOut <= nextWe;
    end
  end
endmodule

// File: rtl/byteAluFlagsChecker.sv
module byteAluFlagsChecker
  import aluPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opStrobe,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] condIn,
  input logic [DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0] condOut,
  input logic              writeEnOut
);
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !opStrobe |=> $stable(resultOut) && $stable(condOut) && $stable(writeEnOut)); // R1

  AST_ADD_CLEARS_SUBTR: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && (opCode == 4'd0 || opCode == 4'd1) |=> !condOut[B_SUBTR]); // R2

  AST_SUB_SETS_SUBTR: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && (opCode == 4'd2 || opCode == 4'd3 || opCode == 4'd10) |=> condOut[B_SUBTR]); // R3

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && opCode == 4'd4 |=> resultOut == $past(accIn) && !writeEnOut); // R4

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && opCode >= 4'd5 && opCode <= 4'd7 |=> !condOut[B_CARRY] && !condOut[B_SUBTR]); // R5

  AST_INC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && opCode == 4'd8 |=> condOut[B_CARRY] == $past(condIn[B_CARRY])); // R6

  AST_DEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && opCode == 4'd9 |=> condOut[B_CARRY] == $past(condIn[B_CARRY])); // R7

  AST_UNUSED_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe && opCode >= 4'd11 |=> condOut == $past(condIn) && resultOut == $past(accIn)); // R9

  AST_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe |=> writeEnOut == ($past(opCode) != 4'd4 && $past(opCode) <= 4'd10)); // R10
endmodule

bind byteAluFlags byteAluFlagsChecker u_chk (
  .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .opCode(opCode), .accIn(accIn),
  .condIn(condIn), .resultOut(resultOut), .condOut(condOut), .writeEnOut(writeEnOut)
);

// File: tb/byteAluFlags_tb.sv
module byteAluFlags_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opStrobe = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] accIn = '0, operandIn = '0, condIn = '0;
  logic [7:0] resultOut, condOut;
  logic       writeEnOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byteAluFlags u_dut (
    .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .opCode(opCode), .accIn(accIn),
    .operandIn(operandIn), .condIn(condIn), .resultOut(resultOut), .condOut(condOut),
    .writeEnOut(writeEnOut)
  );

  // {req, op, acc, operand, condIn, expResult, expCond, expWe}
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {8'd2,  4'd0,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h94, 1'b1},
    {8'd2,  4'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h51, 1'b1},
    {8'd3,  4'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'hBB, 1'b1},
    {8'd3,  4'd3,  8'h00, 8'h00, 8'h01, 8'hFF, 8'hBB, 1'b1},
    {8'd4,  4'd4,  8'h40, 8'h28, 8'h00, 8'h40, 8'h3A, 1'b0},
    {8'd5,  4'd5,  8'hF0, 8'h3C, 8'h01, 8'h30, 8'h34, 1'b1},
    {8'd5,  4'd7,  8'h55, 8'h55, 8'hFF, 8'h00, 8'h44, 1'b1},
    {8'd5,  4'd6,  8'h01, 8'h02, 8'h00, 8'h03, 8'h04, 1'b1},
    {8'd6,  4'd8,  8'h7F, 8'h00, 8'h01, 8'h80, 8'h95, 1'b1},
    {8'd7,  4'd9,  8'h80, 8'h00, 8'h00, 8'h7F, 8'h3E, 1'b1},
    {8'd8,  4'd10, 8'h80, 8'h00, 8'h00, 8'h80, 8'h87, 1'b1},
    {8'd9,  4'd13, 8'h12, 8'h77, 8'hA5, 8'h12, 8'hA5, 1'b0},
    {8'd10, 4'd15, 8'h9C, 8'h00, 8'h3C, 8'h9C, 8'h3C, 1'b0}
  };

  task automatic check(input int req, input logic [7:0] gotR, input logic [7:0] expR,
                       input logic [7:0] gotC, input logic [7:0] expC,
                       input logic gotW, input logic expW);
    checks++;
    if (gotR !== expR || gotC !== expC || gotW !== expW) begin
      errors++;
      $display("FAIL R%0d: result %h cond %h we %b, expected result %h cond %h we %b",
               req, gotR, gotC, gotW, expR, expC, expW);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c);
    @(negedge clk);
    opCode = op; accIn = a; operandIn = b; condIn = c; opStrobe = 1'b1;
    @(negedge clk);
    opStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, resultOut, 8'h00, condOut, 8'h00, writeEnOut, 1'b0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][44:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      check(int'(VEC[i][52:45]), resultOut, VEC[i][16:9], condOut, VEC[i][8:1],
            writeEnOut, VEC[i][0]);
    end
    // R1: hold with strobe low while inputs change
    apply(4'd0, 8'h10, 8'h20, 8'h00);
    opCode = 4'd2; accIn = 8'hEE; operandIn = 8'h11; condIn = 8'hFF;
    repeat (2) @(negedge clk);
    check(1, resultOut, 8'h30, condOut, 8'h20, writeEnOut, 1'b1);
    // R4: compare with equal operands gives zero, bits 5/3 from operand
    apply(4'd4, 8'h2A, 8'h2A, 8'h00);
    check(4, resultOut, 8'h2A, condOut, 8'h6A, writeEnOut, 1'b0);
    // R8: negate of zero yields zero, no borrow
    apply(4'd10, 8'h00, 8'h00, 8'hFF);
    check(8, resultOut, 8'h00, condOut, 8'h42, writeEnOut, 1'b1);
    // R6: increment wraps 0xFF to 0 with carry kept clear
    apply(4'd8, 8'hFF, 8'h00, 8'h00);
    check(6, resultOut, 8'h00, condOut, 8'h50, writeEnOut, 1'b1);
    // R7: decrement of 0x01, carry kept set
    apply(4'd9, 8'h01, 8'h00, 8'h01);
    check(7, resultOut, 8'h00, condOut, 8'h43, writeEnOut, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule